// File: doc/BRIEF.md
# Network Interface Interrupt Delay and Moderation

This block sits between the receive and transmit completion logic of a network interface and the interrupt request line. Completion events do not raise an interrupt directly. Each direction has two delay timers. One restarts on every completion and fires after a quiet gap. The other starts on the first completion after an idle spell and fires at a fixed time after it, however many further completions arrive. When either timer of a direction runs out, the block pulses a flush request to that direction's descriptor cache so that all completed descriptors are written back with no alignment restriction. In the same clock edge it posts that direction's cause as an immediate interrupt.

Posted causes collect in a pending register and are gated by a mask register. A throttle timer spaces out the rising edges of the interrupt line. Throttled posts, such as the transmit writeback-complete event, wait for the throttle to run out. Immediate posts from the delay timers and mask writes bypass it. Software reads the pending register through a read strobe, which also clears it. All timers count a shared time-base strobe, `tick_i`, which the surrounding chip pulses once per 1024 ns.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset `irq_o`, `pend_o`, `rx_flush_o` and `tx_flush_o` are 0, the mask is 0 and all timers are idle.
- R2: The per-completion timer of a direction is loaded with its limit on every completion event. It fires on the edge that samples the limit-th `tick_i` after the most recent event.
- R3: The absolute timer of a direction is loaded only by a completion that arrives while it is idle. Later events do not reload it. It fires on the edge that samples the limit-th `tick_i` after that first event.
- R4: When a direction's timer fires, that direction's flush output is high for exactly the following cycle, both timers of the direction return to idle, and the cause bit is set in the same edge. Bit 0 is the receive cause and bit 1 is the transmit cause. No flush occurs without a firing.
- R5: A delay limit of 0 disables that timer. A completion event then fires the direction in the same edge.
- R6: A post always sets its pending bit. `irq_o` can be high only while some pending bit is also set in the mask.
- R7: After `irq_o` rises, the throttle counter is loaded with the throttle limit and counts `tick_i`. While it is nonzero, a throttled post cannot raise `irq_o`. The line rises on the first edge where the counter is zero.
- R8: A post from a firing delay timer raises `irq_o` in the same edge, even while the throttle counter is nonzero.
- R9: A pulse on `tx_wb_done_i` posts the transmit cause (bit 1) through the throttled path.
- R10: A mask write re-evaluates the line in the same edge. Unmasking a pending cause raises `irq_o`, and masking all pending causes drops it.
- R11: `pend_o` shows the pending causes. An edge with `pend_rd_i` high clears them and drops `irq_o`. A post sampled in the same edge survives the clear.
- R12: A configuration write uses `cfg_sel_i` to pick the target: 0 receive per-completion limit, 1 receive absolute limit, 2 transmit per-completion limit, 3 transmit absolute limit, 4 throttle limit, 5 mask (from the low two bits of `cfg_wdata_i`). A new limit takes effect at the next timer load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base strobe, one pulse per 1024 ns |
| rx_done_i | input | 1 | Receive completion event |
| tx_done_i | input | 1 | Transmit completion event |
| tx_wb_done_i | input | 1 | Transmit descriptor writeback complete |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_wdata_i | input | TW | Configuration write data |
| pend_rd_i | input | 1 | Pending read strobe, clears pending |
| pend_o | output | 2 | Pending causes (bit 0 receive, bit 1 transmit) |
| rx_flush_o | output | 1 | Receive descriptor flush request pulse |
| tx_flush_o | output | 1 | Transmit descriptor flush request pulse |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench sends a second completion partway through a countdown. A per-completion timer that failed to restart would flush two ticks early, and an absolute timer that did restart would flush late, so the bench checks both. It lets many ticks pass after a flush to catch a sibling timer that was not cancelled and later produces an unexpected flush. For the throttle it checks that a throttled post stays silent through every tick of the window and rises exactly one cycle after the window ends, and that a timer firing inside a live window raises the line at once. It also checks that a post arriving in the same edge as a pending read is not lost, and that masking drops the line while the pending bit is kept.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
   localparam int NCAUSE    = 2;
   localparam int CAUSE_RX  = 0;
   localparam int CAUSE_TX  = 1;
   localparam int NDIR      = 2;
   localparam int NLIMIT    = 2 * NDIR;
   localparam int SEL_W     = 3;
   localparam logic [SEL_W-1:0] SEL_THROTTLE = 3'd4;
   localparam logic [SEL_W-1:0] SEL_MASK     = 3'd5;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
   parameter int TW       = 16,
   parameter bit ABSOLUTE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          event_i,
   input  logic          clear_i,
   input  logic [TW-1:0] limit_i,
   output logic          expire_o
);
   localparam logic [TW-1:0] ONE = TW'(1);

   if (TW < 2) begin : g_bad_width
      $error("irq_delay_timer: TW must be at least 2");
   end

   logic          active_q;
   logic [TW-1:0] cnt_q;
   logic          load_ok;
   logic          zero_lim;
   logic          load;

   if (ABSOLUTE) begin : g_abs
      assign load_ok = !active_q;
   end else begin : g_pkt
      assign load_ok = 1'b1;
   end

   assign zero_lim = (limit_i == '0);
   assign load     = event_i && !zero_lim && load_ok;
   assign expire_o = (event_i && zero_lim) || (active_q && tick_i && cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (load) begin
         active_q <= 1'b1;
         cnt_q    <= limit_i;
      end else if (active_q && tick_i) begin
         if (cnt_q == ONE) active_q <= 1'b0;
         cnt_q <= cnt_q - ONE;
      end
   end

   if (ABSOLUTE) begin : g_abs_chk
      // R3: a running absolute timer ignores further events
      a_r3_abs_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (active_q && event_i && !clear_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
   end else begin : g_pkt_chk
      // R2: every event reloads the per-completion timer
      a_r2_pkt_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (event_i && !clear_i && limit_i != '0) |=> (active_q && cnt_q == $past(limit_i)));
   end
endmodule

// File: rtl/irq_dir_delay.sv
module irq_dir_delay #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          event_i,
   input  logic [TW-1:0] pkt_lim_i,
   input  logic [TW-1:0] abs_lim_i,
   output logic          fire_o
);
   localparam int NTMR = 2;

   logic [TW-1:0]   lim [NTMR];
   logic [NTMR-1:0] expire;

   assign lim[0] = pkt_lim_i;
   assign lim[1] = abs_lim_i;
   assign fire_o = |expire;

   for (genvar k = 0; k < NTMR; k++) begin : g_tmr
      irq_delay_timer #(.TW(TW), .ABSOLUTE(k == 1)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick_i),
         .event_i  (event_i),
         .clear_i  (fire_o),
         .limit_i  (lim[k]),
         .expire_o (expire[k])
      );
   end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
   parameter int NC = 2,
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [NC-1:0] post_imm_i,
   input  logic [NC-1:0] post_thr_i,
   input  logic          mask_we_i,
   input  logic [NC-1:0] mask_wdata_i,
   input  logic          thr_we_i,
   input  logic [TW-1:0] thr_wdata_i,
   input  logic          rd_i,
   output logic [NC-1:0] pend_o,
   output logic          irq_o
);
   localparam logic [TW-1:0] ONE = TW'(1);

   if (NC < 1) begin : g_bad_nc
      $error("irq_cause_ctrl: NC must be at least 1");
   end

   logic [NC-1:0] pend_q, pend_n, mask_q, mask_n;
   logic [TW-1:0] thr_lim_q, thr_cnt_q;
   logic          irq_q, irq_n, want, thr_busy, imm_hit;

   assign pend_n   = (rd_i ? '0 : pend_q) | post_imm_i | post_thr_i;
   assign mask_n   = mask_we_i ? mask_wdata_i : mask_q;
   assign want     = |(pend_n & mask_n);
   assign thr_busy = (thr_cnt_q != '0);
   assign imm_hit  = |(post_imm_i & mask_n);

   always_comb begin
      if (!want)                               irq_n = 1'b0;
      else if (imm_hit || mask_we_i || !thr_busy) irq_n = 1'b1;
      else                                     irq_n = irq_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= '0;
         mask_q    <= '0;
         thr_lim_q <= '0;
         thr_cnt_q <= '0;
         irq_q     <= 1'b0;
      end else begin
         pend_q <= pend_n;
         mask_q <= mask_n;
         irq_q  <= irq_n;
         if (thr_we_i) thr_lim_q <= thr_wdata_i;
         if (irq_n && !irq_q)        thr_cnt_q <= thr_lim_q;
         else if (tick_i && thr_busy) thr_cnt_q <= thr_cnt_q - ONE;
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = irq_q;

   // R6: the line needs a pending, unmasked cause
   a_r6_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> |(pend_q & mask_q));
   // R7: a live throttle window keeps a low line low against throttled posts
   a_r7_throttle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_q && thr_busy && post_imm_i == '0 && !mask_we_i) |=> !irq_q);
   // R11: a read with no post leaves nothing pending and the line low
   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && post_imm_i == '0 && post_thr_i == '0) |=> (pend_q == '0 && !irq_q));
   // R6: posted causes are always latched
   a_r6_post_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ((post_imm_i | post_thr_i) != '0) |=> ((pend_q & $past(post_imm_i | post_thr_i)) == $past(post_imm_i | post_thr_i)));
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
   import irq_mod_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_i,
   input  logic                       rx_done_i,
   input  logic                       tx_done_i,
   input  logic                       tx_wb_done_i,
   input  logic                       cfg_we_i,
   input  logic [2:0]                 cfg_sel_i,
   input  logic [TW-1:0]              cfg_wdata_i,
   input  logic                       pend_rd_i,
   output logic [1:0]                 pend_o,
   output logic                       rx_flush_o,
   output logic                       tx_flush_o,
   output logic                       irq_o
);
   if (TW < 2) begin : g_bad_width
      $error("nic_irq_moderator: TW must be at least 2");
   end

   logic [TW-1:0]     lim_q [NLIMIT];
   logic [NDIR-1:0]   evt, fire, flush_q;
   logic [NCAUSE-1:0] post_imm, post_thr;

   for (genvar i = 0; i < NLIMIT; i++) begin : g_lim
      always_ff @(posedge clk) begin
         if (!rst_n)                                  lim_q[i] <= '0;
         else if (cfg_we_i && cfg_sel_i == SEL_W'(i)) lim_q[i] <= cfg_wdata_i;
      end
   end

   assign evt[CAUSE_RX] = rx_done_i;
   assign evt[CAUSE_TX] = tx_done_i;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      irq_dir_delay #(.TW(TW)) u_dir (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .event_i   (evt[d]),
         .pkt_lim_i (lim_q[2*d]),
         .abs_lim_i (lim_q[2*d+1]),
         .fire_o    (fire[d])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) flush_q[d] <= 1'b0;
         else        flush_q[d] <= fire[d];
      end

      // R4: a flush pulse comes with its cause pending
      a_r4_flush_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
         flush_q[d] |-> pend_o[d]);
   end

   assign post_imm           = fire;
   assign post_thr[CAUSE_RX] = 1'b0;
   assign post_thr[CAUSE_TX] = tx_wb_done_i;

   irq_cause_ctrl #(.NC(NCAUSE), .TW(TW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .post_imm_i   (post_imm),
      .post_thr_i   (post_thr),
      .mask_we_i    (cfg_we_i && cfg_sel_i == SEL_MASK),
      .mask_wdata_i (cfg_wdata_i[NCAUSE-1:0]),
      .thr_we_i     (cfg_we_i && cfg_sel_i == SEL_THROTTLE),
      .thr_wdata_i  (cfg_wdata_i),
      .rd_i         (pend_rd_i),
      .pend_o       (pend_o),
      .irq_o        (irq_o)
   );

   assign rx_flush_o = flush_q[CAUSE_RX];
   assign tx_flush_o = flush_q[CAUSE_TX];

   // R8: a firing timer with its cause unmasked raises the line at once
   a_r8_immediate_raise: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q[CAUSE_RX] && $past(rst_n) && $past(u_ctrl.mask_q[CAUSE_RX]) && !$past(cfg_we_i) |-> irq_o);
endmodule

// File: tb/sim_nic_irq_moderator.sv
module sim_nic_irq_moderator;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0, rx_done_i = 1'b0, tx_done_i = 1'b0, tx_wb_done_i = 1'b0;
   logic          cfg_we_i = 1'b0, pend_rd_i = 1'b0;
   logic [2:0]    cfg_sel_i = '0;
   logic [TW-1:0] cfg_wdata_i = '0;
   logic [1:0]    pend_o;
   logic          rx_flush_o, tx_flush_o, irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   int exp_q[$];   // expected flush order: 0 receive, 1 transmit

   always #10 clk = ~clk;

   nic_irq_moderator #(.TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_done_i(rx_done_i),
      .tx_done_i(tx_done_i), .tx_wb_done_i(tx_wb_done_i), .cfg_we_i(cfg_we_i),
      .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .pend_rd_i(pend_rd_i),
      .pend_o(pend_o), .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o), .irq_o(irq_o)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // scoreboard monitor: each flush pulse must match the next expected kind
   task automatic pop_flush(int kind);
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL R4: actual=unexpected flush kind %0d expected=none", kind);
      end else begin
         int e = exp_q.pop_front();
         if (e != kind) begin
            errors++;
            $display("FAIL R4: actual=flush kind %0d expected=kind %0d", kind, e);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rx_flush_o) pop_flush(0);
         if (tx_flush_o) pop_flush(1);
      end
   end

   task automatic step();
      @(negedge clk);
   endtask
   task automatic do_tick();
      tick_i = 1'b1; step(); tick_i = 1'b0;
   endtask
   task automatic ticks(int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask
   task automatic ev_rx();
      rx_done_i = 1'b1; step(); rx_done_i = 1'b0;
   endtask
   task automatic ev_tx();
      tx_done_i = 1'b1; step(); tx_done_i = 1'b0;
   endtask
   task automatic wb_tx();
      tx_wb_done_i = 1'b1; step(); tx_wb_done_i = 1'b0;
   endtask
   task automatic rd_pend();
      pend_rd_i = 1'b1; step(); pend_rd_i = 1'b0;
   endtask
   task automatic cfg_wr(int sel, int val);
      cfg_we_i = 1'b1; cfg_sel_i = 3'(sel); cfg_wdata_i = TW'(val);
      step();
      cfg_we_i = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      check("R1 irq", irq_o, 0);
      check("R1 pend", pend_o, 0);
      check("R1 flush", {rx_flush_o, tx_flush_o}, 0);

      // R12: program limits, throttle and mask
      cfg_wr(5, 3); cfg_wr(4, 0);
      cfg_wr(0, 3); cfg_wr(1, 10); cfg_wr(2, 4); cfg_wr(3, 20);

      // R2: restart on a second event
      ev_rx(); ticks(2);
      check("R2 no early flush", rx_flush_o, 0);
      ev_rx(); ticks(2);
      check("R2 restarted", rx_flush_o, 0);
      exp_q.push_back(0);
      do_tick();
      check("R2/R12 rx flush after limit", rx_flush_o, 1);
      check("R4 rx cause pending", pend_o, 1);
      check("R8 irq raised", irq_o, 1);
      step();
      check("R4 flush one cycle", rx_flush_o, 0);
      ticks(10);
      check("R4 sibling timer cancelled", pend_o, 1);
      check("R11 pend visible", pend_o, 1);
      rd_pend();
      check("R11 pend cleared", pend_o, 0);
      check("R11 irq dropped", irq_o, 0);

      // R3: absolute timer not reloaded
      cfg_wr(0, 50); cfg_wr(1, 4);
      ev_rx(); ticks(2); ev_rx(); do_tick(); ev_rx();
      check("R3 no flush before limit", rx_flush_o, 0);
      exp_q.push_back(0);
      do_tick();
      check("R3 rx flush at absolute limit", rx_flush_o, 1);
      rd_pend();

      // R5: zero limit fires at once
      cfg_wr(2, 0);
      exp_q.push_back(1);
      ev_tx();
      check("R5 tx flush same edge", tx_flush_o, 1);
      check("R5 tx cause pending", pend_o, 2);
      rd_pend();

      // R6 / R9 / R10: mask behaviour
      cfg_wr(5, 1);
      wb_tx();
      check("R9 tx cause posted", pend_o, 2);
      check("R6 masked cause keeps line low", irq_o, 0);
      cfg_wr(5, 3);
      check("R10 unmask raises", irq_o, 1);
      cfg_wr(5, 1);
      check("R10 mask drops", irq_o, 0);
      check("R10 pending kept", pend_o, 2);
      pend_rd_i = 1'b1; tx_wb_done_i = 1'b1; step();
      pend_rd_i = 1'b0; tx_wb_done_i = 1'b0;
      check("R11 same-edge post survives", pend_o, 2);
      rd_pend();
      check("R11 cleared", pend_o, 0);
      cfg_wr(5, 3);

      // R7: throttle window
      cfg_wr(4, 3);
      wb_tx();
      check("R9 idle throttle raises", irq_o, 1);
      rd_pend();
      check("R11 irq low after read", irq_o, 0);
      wb_tx();
      check("R7 pend during window", pend_o, 2);
      check("R7 held during window", irq_o, 0);
      ticks(3);
      check("R7 held through last tick", irq_o, 0);
      step();
      check("R7 rises after window", irq_o, 1);

      // R8: immediate post bypasses a live window
      rd_pend();
      cfg_wr(0, 2); cfg_wr(1, 30);
      ev_rx(); do_tick();
      exp_q.push_back(0);
      do_tick();
      check("R8 rx flush", rx_flush_o, 1);
      check("R8 irq bypasses throttle", irq_o, 1);
      check("R8 pend", pend_o, 1);

      ticks(5);
      check("R4 all expected flushes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule